// File: doc/BRIEF.md
# Triangular Spread-Spectrum Multiplier Modulator

This block sits beside a clock synthesizer's feedback divider and runs on the divided reference clock. Each reference cycle it produces a fixed-point feedback multiplier. The value is a programmed integer base plus a signed offset that follows a triangle wave. The offset first climbs to a positive peak, then falls through zero to the matching negative peak, and finally climbs back to zero. Because the multiplier sweeps back and forth, the synthesized clock's energy is spread around its centre frequency instead of sitting in one narrow line.

Two settings control the sweep. The length of one quarter of the triangle, in reference cycles, is a divider given as a mantissa shifted left by an exponent. The per-cycle change of the offset is a step with three integer bits and an 18-bit fraction. The peak deviation is step × divider. The modulation rate is the reference rate divided by four times the divider. The step and divider settings are captured only while spreading is off, so software fixes the base and divider before turning spreading on. If a setting could drive the multiplier out of its legal range, or the mantissa is zero, the block reports a configuration error and holds the output at the plain base value.

Top module: `ssc_tri_modulator`

## Requirements
- R1: While `ssc_en` is low, `mult_fx` equals the base multiplier in bits [28:18] with the 18 fraction bits [17:0] zero.
- R2: With divider D = `div_mant` × 2^`div_exp`, the offset rises for D reference cycles, falls for 2·D cycles and rises for D cycles, then repeats with period 4·D.
- R3: While modulating, the offset changes by exactly `step_fx` (an 18-bit fraction, LSB = 2^-18) every reference cycle. It reaches +step·D at the end of the first quarter and −step·D at the end of the third.
- R4: On the first cycle `ssc_en` is sampled high after being low, the offset restarts at zero in the rising quarter. It takes its first step on the following cycle.
- R5: `cfg_err` is high when base·2^18 − step·D < 20·2^18 or base·2^18 + step·D > 2045·2^18. While it is high, `mult_fx` stays at the plain base value and no modulation occurs.
- R6: A captured mantissa of zero raises `cfg_err` and holds modulation off.
- R7: `div_mant`, `div_exp` and `step_fx` are captured on every clock edge at which `ssc_en` is low. Changes made while it is high have no effect until spreading is next turned on.
- R8: While modulating without error, `mult_fx` stays within [20·2^18, 2045·2^18].
- R9: Asynchronous reset clears the captured settings and the offset, so `cfg_err` is high and `mult_fx` shows the plain base value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ssc_en | input | 1 | Spreading enable |
| base_mult | input | 11 | Integer base multiplier |
| div_mant | input | 7 | Quarter-period divider mantissa |
| div_exp | input | 3 | Quarter-period divider exponent |
| step_fx | input | 21 | Per-cycle step, 3 integer bits and 18 fraction bits |
| mult_fx | output | 29 | Instantaneous multiplier, 11 integer bits and 18 fraction bits |
| cfg_err | output | 1 | Configuration out of range or zero mantissa |

## Verification
Two events can fall in the same cycle: a restart caused by spreading being turned back on, and the direction reversal at a quarter boundary. The bench drops the enable for one cycle so that the re-enable edge lands exactly where a quarter would have expired. The restart must win: the offset returns to zero, the sequence rises again, and no reversal is seen. A second collision is a settings change written in the same cycle as the enable rises. The bench judges every cycle against a closed-form triangle computed from its own record of the captured settings.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int MULT_W     = 11;
  localparam int FRAC_W     = 18;
  localparam int MANT_W     = 7;
  localparam int EXP_W      = 3;
  localparam int STEP_INT_W = 3;
  localparam int MIN_MULT   = 20;
  localparam int MAX_MULT   = 2045;

  localparam int STEP_W = STEP_INT_W + FRAC_W;
  localparam int DIV_W  = MANT_W + (1 << EXP_W) - 1;
  localparam int DM_W   = STEP_W + DIV_W;
  localparam int ACC_W  = DM_W + 2;
  localparam int OUT_W  = MULT_W + FRAC_W;

  typedef logic [DIV_W-1:0]         div_t;
  typedef logic [DM_W-1:0]          dm_t;
  typedef logic signed [ACC_W-1:0]  acc_t;

  // quarter length in reference cycles
  function automatic div_t calc_div(input logic [MANT_W-1:0] mant,
                                    input logic [EXP_W-1:0] expo);
    return DIV_W'(mant) << expo;
  endfunction

  // peak deviation, same fraction scaling as the step
  function automatic dm_t calc_dm(input logic [STEP_W-1:0] step, input div_t div);
    return DM_W'(step) * DM_W'(div);
  endfunction

  // true when base +/- deviation leaves the legal multiplier window
  function automatic logic range_bad(input logic [MULT_W-1:0] base, input dm_t dm);
    logic [ACC_W-1:0] b, lo, hi, d;
    b  = ACC_W'(base) << FRAC_W;
    lo = ACC_W'(MIN_MULT) << FRAC_W;
    hi = ACC_W'(MAX_MULT) << FRAC_W;
    d  = ACC_W'(dm);
    return (b < lo + d) || (b + d > hi);
  endfunction
endpackage

// File: rtl/ssc_cfg_shadow.sv
module ssc_cfg_shadow
  import ssc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en_i,
  input  logic [MULT_W-1:0]      base_i,
  input  logic [MANT_W-1:0]      mant_i,
  input  logic [EXP_W-1:0]       exp_i,
  input  logic [STEP_W-1:0]      step_i,
  output div_t                   div_o,
  output logic [STEP_W-1:0]      step_o,
  output dm_t                    dm_o,
  output logic                   err_o
);
  logic [MANT_W-1:0] mant_q;
  logic [EXP_W-1:0]  exp_q;
  logic [STEP_W-1:0] step_q;
  logic              mant_zero;
  logic              out_of_range;

  // settings follow the inputs only while spreading is off
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mant_q <= '0;
      exp_q  <= '0;
      step_q <= '0;
    end else if (!en_i) begin
      mant_q <= mant_i;
      exp_q  <= exp_i;
      step_q <= step_i;
    end
  end

  assign div_o        = calc_div(mant_q, exp_q);
  assign step_o       = step_q;
  assign dm_o         = calc_dm(step_q, div_o);
  assign mant_zero    = (mant_q == '0);
  assign out_of_range = range_bad(base_i, dm_o);
  assign err_o        = mant_zero || out_of_range;

  p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> $stable({mant_q, exp_q, step_q}));
endmodule

// File: rtl/ssc_quarter_timer.sv
module ssc_quarter_timer
  import ssc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  div_t       div_i,
  output logic [1:0] phase_o,
  output logic       quarter_end_o,
  output logic       rising_o
);
  div_t       cnt_q;
  logic [1:0] phase_q;

  assign quarter_end_o = run_i && (cnt_q == div_i - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 2'd0;
    end else if (!run_i) begin
      cnt_q   <= '0;
      phase_q <= 2'd0;
    end else if (quarter_end_o) begin
      cnt_q   <= '0;
      phase_q <= phase_q + 2'd1;
    end else begin
      cnt_q   <= cnt_q + DIV_W'(1);
    end
  end

  assign phase_o  = phase_q;
  // quarters 0 and 3 climb, quarters 1 and 2 descend
  assign rising_o = (phase_q == 2'd0) || (phase_q == 2'd3);

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q < div_i));
  p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !quarter_end_o) |=> $stable(phase_q));
  p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && quarter_end_o) |=> (phase_q == $past(phase_q) + 2'd1));
endmodule

// File: rtl/ssc_ramp_acc.sv
module ssc_ramp_acc
  import ssc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              rising_i,
  input  logic              quarter_end_i,
  input  logic [1:0]        phase_i,
  input  logic [STEP_W-1:0] step_i,
  input  dm_t               dm_i,
  output acc_t              offset_o
);
  acc_t offset_q;
  acc_t step_s;
  acc_t dm_s;

  assign step_s = $signed(ACC_W'(step_i));
  assign dm_s   = $signed(ACC_W'(dm_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        offset_q <= '0;
    else if (!run_i)   offset_q <= '0;
    else if (rising_i) offset_q <= offset_q + step_s;
    else               offset_q <= offset_q - step_s;
  end

  assign offset_o = offset_q;

  p_peak_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && quarter_end_i && phase_i == 2'd0) |=> (offset_q == dm_s));
  p_trough_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && quarter_end_i && phase_i == 2'd2) |=> (offset_q == -dm_s));
  p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && quarter_end_i && phase_i == 2'd3) |=> (offset_q == '0));
endmodule

// File: rtl/ssc_tri_modulator.sv
module ssc_tri_modulator
  import ssc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ssc_en,
  input  logic [10:0] base_mult,
  input  logic [6:0]  div_mant,
  input  logic [2:0]  div_exp,
  input  logic [20:0] step_fx,
  output logic [28:0] mult_fx,
  output logic        cfg_err
);
  logic              en_q;
  logic              start_evt;
  logic              run;
  logic              modulating;
  div_t              div_w;
  dm_t               dm_w;
  logic [STEP_W-1:0] step_w;
  logic [1:0]        phase_w;
  logic              quarter_end;
  logic              rising;
  acc_t              offset_w;
  acc_t              base_ext;
  acc_t              sum_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= ssc_en;
  end

  assign start_evt  = ssc_en && !en_q;
  assign run        = ssc_en && en_q && !cfg_err;
  assign modulating = ssc_en && !cfg_err;

  ssc_cfg_shadow u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (ssc_en),
    .base_i (base_mult),
    .mant_i (div_mant),
    .exp_i  (div_exp),
    .step_i (step_fx),
    .div_o  (div_w),
    .step_o (step_w),
    .dm_o   (dm_w),
    .err_o  (cfg_err)
  );

  ssc_quarter_timer u_timer (
    .clk           (clk),
    .rst_n         (rst_n),
    .run_i         (run),
    .div_i         (div_w),
    .phase_o       (phase_w),
    .quarter_end_o (quarter_end),
    .rising_o      (rising)
  );

  ssc_ramp_acc u_ramp (
    .clk           (clk),
    .rst_n         (rst_n),
    .run_i         (run),
    .rising_i      (rising),
    .quarter_end_i (quarter_end),
    .phase_i       (phase_w),
    .step_i        (step_w),
    .dm_i          (dm_w),
    .offset_o      (offset_w)
  );

  assign base_ext = $signed(ACC_W'(base_mult) << FRAC_W);
  assign sum_w    = base_ext + offset_w;
  assign mult_fx  = modulating ? sum_w[OUT_W-1:0] : {base_mult, {FRAC_W{1'b0}}};

  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (offset_w == '0));
  p_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    modulating |-> (mult_fx >= (OUT_W'(MIN_MULT) << FRAC_W) &&
                    mult_fx <= (OUT_W'(MAX_MULT) << FRAC_W)));
  p_err_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> (offset_w == '0));
endmodule

// File: tb/ssc_tri_modulator_tb_top.sv
module ssc_tri_modulator_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ssc_en = 1'b0;
  logic [10:0] base_mult = 11'd25;
  logic [6:0]  div_mant = 7'd100;
  logic [2:0]  div_exp = 3'd1;
  logic [20:0] step_fx = 21'd327;
  logic [28:0] mult_fx;
  logic        cfg_err;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  // bench record of captured settings and ramp position
  longint sh_m = 0, sh_e = 0, sh_s = 0;
  bit     en_prev = 0;
  longint t = 0;

  always #4 clk = ~clk;

  ssc_tri_modulator dut_i (
    .clk(clk), .rst_n(rst_n), .ssc_en(ssc_en), .base_mult(base_mult),
    .div_mant(div_mant), .div_exp(div_exp), .step_fx(step_fx),
    .mult_fx(mult_fx), .cfg_err(cfg_err)
  );

  localparam longint ONE = 64'd1 << 18;

  function automatic bit err_of(longint b, longint m, longint e, longint s);
    longint dm = s * (m << e);
    return (m == 0) || (b * ONE - dm < 20 * ONE) || (b * ONE + dm > 2045 * ONE);
  endfunction

  function automatic longint tri_of(longint tt, longint d, longint s);
    longint p = tt % (4 * d);
    if (p <= d)          return p * s;
    else if (p <= 3 * d) return (2 * d - p) * s;
    else                 return (p - 4 * d) * s;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // one reference cycle, model updated at the edge, outputs checked after it
  task automatic tick(string req);
    bit     err_pre, err_post;
    longint expv;
    @(posedge clk);
    err_pre = err_of(base_mult, sh_m, sh_e, sh_s);
    if (!ssc_en) begin
      sh_m = div_mant; sh_e = div_exp; sh_s = step_fx;
    end
    if (ssc_en && en_prev && !err_pre) t++;
    else t = 0;
    en_prev = ssc_en;
    #2;
    err_post = err_of(base_mult, sh_m, sh_e, sh_s);
    expv = base_mult * ONE;
    if (ssc_en && !err_post) expv += tri_of(t, sh_m << sh_e, sh_s);
    chk(longint'(mult_fx) == expv, req, longint'(mult_fx), expv);
    chk(cfg_err == err_post, {req, " cfg_err"}, cfg_err, err_post);
  endtask

  task automatic run_n(int n, string req);
    for (int i = 0; i < n; i++) tick(req);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R9 reset state
    #3;
    chk(cfg_err == 1'b1, "R9 reset err", cfg_err, 1);
    chk(longint'(mult_fx) == 25 * ONE, "R9 R1 reset out", mult_fx, 25 * ONE);
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 disabled, settings captured
    run_n(3, "R1");
    // directed example: D=200, step 327, peak 65400
    ssc_en = 1'b1;
    tick("R4 start");
    chk(longint'(mult_fx) == 25 * ONE, "R4 first cycle zero", mult_fx, 25 * ONE);
    run_n(200, "R3");
    chk(longint'(mult_fx) == 25 * ONE + 65400, "R3 peak", mult_fx, 25 * ONE + 65400);
    run_n(400, "R2");
    chk(longint'(mult_fx) == 25 * ONE - 65400, "R3 trough", mult_fx, 25 * ONE - 65400);
    // R7 changes while running are ignored
    div_mant = 7'd3; step_fx = 21'd9000;
    run_n(300, "R7");
    ssc_en = 1'b0;
    run_n(2, "R1 off");

    // collision: restart at a quarter boundary
    div_mant = 7'd4; div_exp = 3'd1; step_fx = 21'd5000; base_mult = 11'd300;
    tick("R7 capture");
    ssc_en = 1'b1;
    run_n(8, "R2");
    ssc_en = 1'b0;
    tick("R1");
    ssc_en = 1'b1; step_fx = 21'd7777;
    tick("R4 restart");
    chk(longint'(mult_fx) == 300 * ONE, "R4 restart zero", mult_fx, 300 * ONE);
    run_n(40, "R4 R7");
    ssc_en = 1'b0;
    tick("R1");

    // R5 boundaries, D=1, step 1.0
    div_mant = 7'd1; div_exp = 3'd0; step_fx = 21'(ONE);
    base_mult = 11'd21;   tick("R5 low ok");
    chk(cfg_err == 1'b0, "R5 low edge ok", cfg_err, 0);
    base_mult = 11'd20;   tick("R5 low bad");
    chk(cfg_err == 1'b1, "R5 low edge bad", cfg_err, 1);
    base_mult = 11'd2044; tick("R5 high ok");
    chk(cfg_err == 1'b0, "R5 high edge ok", cfg_err, 0);
    ssc_en = 1'b1;        run_n(6, "R8 edge");
    ssc_en = 1'b0;
    base_mult = 11'd2045; tick("R5 high bad");
    ssc_en = 1'b1;        run_n(5, "R5 hold");
    chk(longint'(mult_fx) == 2045 * ONE, "R5 held base", mult_fx, 2045 * ONE);
    ssc_en = 1'b0;

    // R6 mantissa zero
    base_mult = 11'd500; div_mant = 7'd0; step_fx = 21'd100;
    tick("R6");
    ssc_en = 1'b1; run_n(5, "R6 hold");
    chk(cfg_err == 1'b1, "R6 err", cfg_err, 1);
    ssc_en = 1'b0; tick("R6");

    // constrained random sweeps
    for (int k = 0; k < 24; k++) begin
      longint d;
      div_mant  = 7'($urandom_range(1, 7));
      div_exp   = 3'($urandom_range(0, 3));
      base_mult = 11'($urandom_range(100, 1900));
      d = longint'(div_mant) << div_exp;
      step_fx   = 21'($urandom_range(0, int'((90 * ONE) / d)));
      if (k % 6 == 5) base_mult = 11'($urandom_range(20, 60));
      tick("R7 capture");
      ssc_en = 1'b1;
      run_n(int'(8 * d + 3), "R2 R3 random");
      ssc_en = 1'b0;
      tick("R1 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule